// File: doc/BRIEF.md
# Resolution-Scaled Conversion Sequencer

This block paces a temperature sensor's conversions and keeps the newest result. A signed 12-bit raw sample arrives on an input port. This port stands in for the analog front end and its decimation filter. An internal timer measures out each conversion. The length of a conversion depends on the selected resolution: the shortest period, used for 9-bit mode, is a parameter counted in clock cycles, and each added bit of resolution doubles it.

When a conversion ends, the block captures the sample, cuts it down to the active resolution and stores it as a 16-bit left-justified two's complement word. In the same cycle it raises a one-cycle completion pulse, which the thermostat comparator downstream uses to tell that a new value is ready. The block also accepts a shutdown level. The conversion already running is allowed to finish and its result is stored before the block goes idle. Dropping the level starts continuous conversion again.

The resolution select is sampled only at the start of a conversion. A conversion in flight therefore never changes length or truncation partway through. The asynchronous reset is released through two synchronizing flops.

Top module: `conv_seq`

## Requirements
- R1: The 2-bit resolution select maps code 00 to 9 bits, 01 to 10 bits, 10 to 11 bits and 11 to 12 bits.
- R2: In continuous operation, completion pulses are exactly BASE_TICKS × 2^code cycles apart, where code is the resolution in force for that conversion.
- R3: The result word holds sample bit i in result bit i+4. The sign therefore sits in bit 15 and the sample LSB has a weight of 2^-4 in bit 4. Bits 3..0 are always 0, and every bit below the top 9+code bits is 0.
- R4: While reset is held, the result is 0 and both the pulse and the standby flag are low. After rst_n rises, a first 9-bit conversion starts without any other input. Its pulse appears BASE_TICKS+2 cycles after the release: two cycles of reset synchronization, then one 9-bit period.
- R5: A change of the resolution select takes effect at the next conversion start. The conversion already running keeps its original length.
- R6: The completion pulse lasts one cycle. The result register changes only in the cycle the pulse is high.
- R7: If shutdown is high when a conversion ends, that result is stored, its pulse is given, and standby rises in the same cycle. No further pulse and no result change happens while shutdown stays high.
- R8: Raising shutdown in the middle of a conversion does not shorten or abort it. Its pulse arrives on the normal schedule.
- R9: Once shutdown falls in standby, the block leaves standby on the next edge, samples the resolution select, and starts a new conversion. The first pulse comes one full period after that edge.
- R10: Between pulses the result keeps the last completed value, whatever the sample input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_sel | input | 2 | Resolution select, 00 = 9 bits up to 11 = 12 bits |
| shutdown | input | 1 | Level request to stop after the current conversion |
| sample | input | 12 | Raw signed temperature sample from the front end |
| result | output | 16 | Left-justified two's complement result of the last conversion |
| done | output | 1 | One-cycle pulse marking a result update |
| standby | output | 1 | High while the sequencer is stopped |

## Verification
The bench builds the block with BASE_TICKS = 15. This gives periods of 15, 30, 60 and 120 cycles, so every resolution can be run many times within a short run. At that size, the bench sweeps all four resolution codes. For each code it captures sign-extreme and spread-out sample values and compares the stored word with a mask computed from 9+code. It measures the interval between pulses at every code, both across a resolution change and across a shutdown and restart.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int MIN_BITS = 9;
  localparam int RES_W    = 2;

  typedef enum logic [RES_W-1:0] {
    RES_9  = 2'b00,
    RES_10 = 2'b01,
    RES_11 = 2'b10,
    RES_12 = 2'b11
  } res_code_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STBY = 1'b1
  } seq_state_t;

endpackage

// File: rtl/conv_seq_timer.sv
module conv_seq_timer
  import conv_seq_pkg::*;
#(
  parameter int BASE_TICKS = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  res_code_t code,
  output logic      terminal
);

  localparam int CNT_W = $clog2(BASE_TICKS * 8 + 1);
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] period;

  // period doubles per added resolution bit
  assign period   = BASE_C << code;
  assign terminal = run && (cnt_q == period - CNT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (!run || terminal) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  // R2: the count never runs past the active period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period);

  // R8: an idle timer stays parked at zero
  a_r8_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_sel,
  input  logic             shutdown,
  input  logic             terminal,
  output logic             run,
  output logic             standby,
  output res_code_t        act_res
);

  seq_state_t state_q, state_n;
  res_code_t  act_res_q, act_res_n;

  always_comb begin
    state_n   = state_q;
    act_res_n = act_res_q;
    unique case (state_q)
      ST_RUN: begin
        if (terminal) begin
          act_res_n = res_code_t'(res_sel);
          state_n   = shutdown ? ST_STBY : ST_RUN;
        end
      end
      ST_STBY: begin
        if (!shutdown) begin
          act_res_n = res_code_t'(res_sel);
          state_n   = ST_RUN;
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      act_res_q <= RES_9;
    end else begin
      state_q   <= state_n;
      act_res_q <= act_res_n;
    end
  end

  assign run     = (state_q == ST_RUN);
  assign standby = (state_q == ST_STBY);
  assign act_res = act_res_q;

  // R5: resolution is frozen while a conversion is in flight
  a_r5_res_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !terminal) |=> act_res_q == $past(act_res_q));

  // R7: standby persists while shutdown stays requested
  a_r7_stay_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && shutdown) |=> state_q == ST_STBY);

  // R9: dropping shutdown in standby restarts conversion
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && !shutdown) |=> state_q == ST_RUN);

endmodule

// File: rtl/conv_seq_trunc.sv
module conv_seq_trunc
  import conv_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  res_code_t           code,
  output logic [RESULT_W-1:0] word
);

  localparam int PAD = RESULT_W - SAMPLE_W;

  for (genvar b = 0; b < RESULT_W; b++) begin : g_bit
    localparam int RANK = RESULT_W - 1 - b;
    if (b < PAD) begin : g_pad
      assign word[b] = 1'b0;
    end else if (RANK < MIN_BITS) begin : g_always
      assign word[b] = sample[b-PAD];
    end else begin : g_scaled
      // kept only when the active resolution reaches this rank
      assign word[b] = sample[b-PAD] & (code > RES_W'(RANK - MIN_BITS));
    end
  end

endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int BASE_TICKS = 15,
  parameter int SAMPLE_W   = 12,
  parameter int RESULT_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          res_sel,
  input  logic                shutdown,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [RESULT_W-1:0] result,
  output logic                done,
  output logic                standby
);

  localparam int PAD = RESULT_W - SAMPLE_W;

  logic        sync_q1, rst_sync;
  logic        run, terminal;
  res_code_t   act_res;
  logic [RESULT_W-1:0] trunc_word;
  logic [RESULT_W-1:0] result_q, result_n;
  logic        done_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1  <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      sync_q1  <= 1'b1;
      rst_sync <= sync_q1;
    end
  end

  conv_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .res_sel  (res_sel),
    .shutdown (shutdown),
    .terminal (terminal),
    .run      (run),
    .standby  (standby),
    .act_res  (act_res)
  );

  conv_seq_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync),
    .run      (run),
    .code     (act_res),
    .terminal (terminal)
  );

  conv_seq_trunc #(.SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W)) u_trunc (
    .sample (sample),
    .code   (act_res),
    .word   (trunc_word)
  );

  always_comb begin
    result_n = result_q;
    if (terminal) begin
      result_n = trunc_word;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_n;
      done_q   <= terminal;
    end
  end

  assign result = result_q;
  assign done   = done_q;

  // R6: the pulse never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_sync)
    done_q |=> !done_q);

  // R6: the result moves only together with the pulse
  a_r6_result_on_done: assert property (@(posedge clk) disable iff (!rst_sync)
    (result_q != $past(result_q)) |-> done_q);

  // R3: the pad bits below the sample LSB stay clear
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    result_q[PAD-1:0] == '0);

  // R7: no completion while resting in standby
  a_r7_quiet_standby: assert property (@(posedge clk) disable iff (!rst_sync)
    (standby && $past(standby)) |-> !done_q);

endmodule

// File: tb/conv_seq_bench.sv
`timescale 1ns/1ps
module conv_seq_bench;

  localparam int BASE = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  res_sel;
  logic        shutdown;
  logic [11:0] sample;
  logic [15:0] result;
  logic        done;
  logic        standby;

  int cyc;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  conv_seq #(.BASE_TICKS(BASE)) u_conv_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_sel  (res_sel),
    .shutdown (shutdown),
    .sample   (sample),
    .result   (result),
    .done     (done),
    .standby  (standby)
  );

  function automatic logic [15:0] expect_word(logic [11:0] s, int k);
    logic [15:0] w;
    int keep;
    w = {s, 4'h0};
    keep = 9 + k;
    for (int b = 0; b < 16; b++) begin
      if (b < 16 - keep) w[b] = 1'b0;
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int at);
    at = -1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (done) begin
        at = cyc;
        break;
      end
    end
    if (at < 0) check(1'b0, "R2 pulse timeout", 0, 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4 watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t, prev, per, cur;
    logic [11:0] v;
    logic [15:0] last;
    rst_n = 1'b0; res_sel = 2'b00; shutdown = 1'b0; sample = 12'h000;
    repeat (3) @(negedge clk);
    // R4: reset state
    check(result == 16'h0, "R4 reset result", result, 0);
    check(done == 1'b0, "R4 reset done", done, 0);
    check(standby == 1'b0, "R4 reset standby", standby, 0);
    rst_n = 1'b1;
    wait_done(t);
    check(t == BASE + 2, "R4 first pulse cycle", t, BASE + 2);
    check(result == 16'h0, "R3 zero sample", result, 0);
    @(negedge clk);
    check(done == 1'b0, "R6 pulse width", done, 0);
    prev = t;
    cur  = 0;
    last = result;

    for (int k = 0; k < 4; k++) begin
      res_sel = 2'(k);
      per = BASE << cur;
      wait_done(t);
      // R5: conversion in flight keeps the old period
      check(t - prev == per, "R5 old period kept", t - prev, per);
      prev = t;
      cur  = k;
      per  = BASE << k;
      wait_done(t);
      // R1 and R2: new code sets the period
      check(t - prev == per, "R1 R2 period for code", t - prev, per);
      prev = t;
      last = result;
      for (int i = 0; i < 64; i++) begin
        case (i)
          0: v = 12'h7FF;
          1: v = 12'h800;
          2: v = 12'hFFF;
          3: v = 12'h001;
          default: v = 12'((i * 97 + 5) % 4096);
        endcase
        sample = ~v;
        repeat (per / 2) @(negedge clk);
        // R10: result holds while the sample moves
        check(result == last, "R10 hold between pulses", result, last);
        sample = v;
        wait_done(t);
        check(t - prev == per, "R2 steady period", t - prev, per);
        check(result == expect_word(v, k), "R3 truncated word", result, expect_word(v, k));
        prev = t;
        last = result;
      end
    end

    // back to 9-bit for the shutdown sequence
    res_sel = 2'b00;
    wait_done(t); prev = t;
    wait_done(t); prev = t;
    sample = 12'h123;
    repeat (5) @(negedge clk);
    shutdown = 1'b1;
    wait_done(t);
    check(t - prev == BASE, "R8 in-flight completes", t - prev, BASE);
    check(result == expect_word(12'h123, 0), "R7 last result stored", result, expect_word(12'h123, 0));
    check(standby == 1'b1, "R7 standby entered", standby, 1);
    last = result;
    res_sel = 2'b01;
    sample = 12'h456;
    for (int n = 0; n < 4 * BASE; n++) begin
      @(negedge clk);
      if (done || !standby || result != last) begin
        check(1'b0, "R7 quiet in standby", result, last);
        break;
      end
    end
    check(standby == 1'b1 && result == last, "R7 standby held", result, last);
    shutdown = 1'b0;
    prev = cyc;
    wait_done(t);
    check(t == prev + 1 + 2 * BASE, "R9 restart timing", t, prev + 1 + 2 * BASE);
    check(standby == 1'b0, "R9 standby left", standby, 0);
    check(result == expect_word(12'h456, 1), "R9 restart result", result, expect_word(12'h456, 1));
    prev = t;
    wait_done(t);
    check(t - prev == 2 * BASE, "R9 continuous after restart", t - prev, 2 * BASE);
    finish_run();
  end

endmodule